// File: doc/BRIEF.md
# Floating-Point Adder with Operand Ordering and Renormalization

This block adds or subtracts two floating-point numbers, or turns an unsigned integer into a float. Each number is a single word in sign-magnitude form. The sign is the top bit, a biased exponent sits below it, and an explicit mantissa fills the low bits. Because the exponent sits above the mantissa, the magnitude bits of a word can be compared as one unsigned integer. The block uses that compare to order the operands before any arithmetic, so the mantissa difference is never negative.

An operation runs in three registered steps:

1. Compare and order the operands.
2. Shift the smaller operand right by the exponent difference, and add or subtract in the same step.
3. Renormalize the result with a leading-one search and correct the exponent.

The integer conversion uses the same renormalize step. A new operation may start on every clock. Each start produces one done pulse three clock edges later, with the result on the output in that cycle.

Top module: `fadd_unit`

## Requirements
- R1: A word is {sign, exponent[EXP_W], mantissa[MAN_W]}, with defaults of 8 and 18 bits and the sign in bit 26. The exponent bias is 127. A nonzero value has mantissa bit 17 set and an exponent field of at least 1. The value is mantissa·2^(exponent−127−17). Every nonzero result meets this form.
- R2: A start sampled on a rising edge gives done high for one cycle after the third rising edge that follows, with the result valid in that cycle. Starts may arrive on consecutive cycles. done is low after reset, and result holds its last value while done is low.
- R3: The operation codes are 0 for a+b and 1 for a−b; for a−b the sign of b is inverted. The operand with the larger {exponent, mantissa} field, compared as an unsigned integer, is the large one. The result takes the sign of the large operand. Equal magnitudes with opposite effective signs give zero.
- R4: The mantissa of the small operand is shifted right by the exponent difference, and the bits shifted out are dropped without rounding. With a difference of 18 or more, the small operand adds nothing.
- R5: If the mantissa sum carries out, it is shifted right by one, its lowest bit is dropped, and the exponent is increased by one.
- R6: Otherwise, a nonzero result is shifted left until bit 17 is set, and the exponent is lowered by the shift count.
- R7: A zero mantissa result gives the all-zero word, including sign and exponent. Zero operands are all-zero words.
- R8: If the renormalized exponent would fall below 1, the result is flushed to the all-zero word.
- R9: When op bit 1 is set (codes 2 and 3), the low 18 bits of a are taken as an unsigned integer and b is ignored. The result is the float 2^p·(n normalized), with exponent 127+p, where p is the position of the highest set bit. An input of zero gives the all-zero word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts an operation on the operands present at this edge |
| op | input | 2 | 0 add, 1 subtract, 2 or 3 integer-to-float |
| a_in | input | 27 | First operand, or the integer in bits 17:0 |
| b_in | input | 27 | Second operand |
| result | output | 27 | Result word, valid while done is high |
| done | output | 1 | One-cycle pulse marking a valid result |

## Verification
The bench targets the following corner cases, and each one shows up on result when the design gets it wrong:

- **Subtraction with a larger b.** A design that skips the ordering step returns a wrapped mantissa and the wrong sign.
- **Exact cancellation.** Without the zero rule, the output carries a stale exponent or a negative zero.
- **Alignment at differences of 17, 18 and more.** An off-by-one at the shift limit leaves a stray low bit in the sum.
- **Near cancellation that needs a long left shift.** A faulty leading-one search gives the wrong exponent.
- **Exponent floor at 1.** Missing the flush causes exponent wraparound.
- **Conversion from 0, 1 and the full 18-bit range.** These expose a priority search that fails to stop on zero or counts from the wrong end.

// File: rtl/fadd_pkg.sv
package fadd_pkg;
    // bit positions inside the op code
    localparam int OPB_NEG = 0;   // invert the sign of b (subtract)
    localparam int OPB_CVT = 1;   // integer-to-float conversion
endpackage

// File: rtl/fadd_lod.sv
module fadd_lod #(
    parameter int W  = 18,
    localparam int PW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [PW-1:0] pos
);
    // priority search from lsb upward: the highest set bit wins,
    // all-zero input ends with found low
    always_comb begin
        found = 1'b0;
        pos   = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                found = 1'b1;
                pos   = PW'(i);
            end
        end
    end
endmodule

// File: rtl/fadd_order.sv
module fadd_order
    import fadd_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 18,
    localparam int W     = 1 + EXP_W + MAN_W,
    localparam int MAG_W = EXP_W + MAN_W,
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1
) (
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic [1:0]       op,
    output logic             sgn,
    output logic             eff_sub,
    output logic [EXP_W-1:0] exp_big,
    output logic [MAN_W-1:0] man_big,
    output logic [EXP_W-1:0] exp_sml,
    output logic [MAN_W-1:0] man_sml
);
    logic             sgn_a, sgn_b;
    logic [MAG_W-1:0] mag_a, mag_b;
    logic             a_ge;

    always_comb begin
        sgn_a = a[W-1];
        sgn_b = b[W-1] ^ op[OPB_NEG];
        mag_a = a[MAG_W-1:0];
        mag_b = b[MAG_W-1:0];
        a_ge  = (mag_a >= mag_b);

        if (op[OPB_CVT]) begin
            // integer enters as an unnormalized mantissa with the
            // exponent that makes bit MAN_W-1 worth 2^(MAN_W-1)
            sgn     = 1'b0;
            eff_sub = 1'b0;
            exp_big = EXP_W'(BIAS + MAN_W - 1);
            man_big = a[MAN_W-1:0];
            exp_sml = '0;
            man_sml = '0;
        end else begin
            eff_sub = sgn_a ^ sgn_b;
            if (a_ge) begin
                sgn     = sgn_a;
                exp_big = mag_a[MAG_W-1:MAN_W];
                man_big = mag_a[MAN_W-1:0];
                exp_sml = mag_b[MAG_W-1:MAN_W];
                man_sml = mag_b[MAN_W-1:0];
            end else begin
                sgn     = sgn_b;
                exp_big = mag_b[MAG_W-1:MAN_W];
                man_big = mag_b[MAN_W-1:0];
                exp_sml = mag_a[MAG_W-1:MAN_W];
                man_sml = mag_a[MAN_W-1:0];
            end
        end
    end
endmodule

// File: rtl/fadd_align.sv
module fadd_align #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 18
) (
    input  logic             eff_sub,
    input  logic [EXP_W-1:0] exp_big,
    input  logic [MAN_W-1:0] man_big,
    input  logic [EXP_W-1:0] exp_sml,
    input  logic [MAN_W-1:0] man_sml,
    output logic [MAN_W:0]   sum
);
    logic [EXP_W-1:0] diff;
    logic [MAN_W-1:0] shifted;

    always_comb begin
        diff = exp_big - exp_sml;
        if (diff >= EXP_W'(MAN_W))
            shifted = '0;
        else
            shifted = man_sml >> diff;   // truncating alignment
        if (eff_sub)
            sum = {1'b0, man_big} - {1'b0, shifted};
        else
            sum = {1'b0, man_big} + {1'b0, shifted};
    end
endmodule

// File: rtl/fadd_norm.sv
module fadd_norm #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 18,
    localparam int W  = 1 + EXP_W + MAN_W,
    localparam int PW = (MAN_W > 1) ? $clog2(MAN_W) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sgn,
    input  logic [EXP_W-1:0] exp_in,
    input  logic [MAN_W:0]   sum,
    output logic [W-1:0]     word
);
    logic          found;
    logic [PW-1:0] pos;
    logic [PW:0]   lz;
    logic [EXP_W:0] e_wide, e_up, e_dn;
    logic [MAN_W-1:0] man_sh;

    fadd_lod #(.W(MAN_W)) u_lod (
        .vec   (sum[MAN_W-1:0]),
        .found (found),
        .pos   (pos)
    );

    always_comb begin
        lz     = (PW+1)'(MAN_W - 1) - {1'b0, pos};
        e_wide = {1'b0, exp_in};
        e_up   = e_wide + 1'b1;
        e_dn   = e_wide - (EXP_W+1)'(lz);
        man_sh = sum[MAN_W-1:0] << lz;
        if (sum == '0) begin
            word = '0;
        end else if (sum[MAN_W]) begin
            word = {sgn, e_up[EXP_W-1:0], sum[MAN_W:1]};
        end else if (e_wide <= (EXP_W+1)'(lz)) begin
            word = '0;                               // underflow flush
        end else begin
            word = {sgn, e_dn[EXP_W-1:0], man_sh};
        end
    end

    // R6: the detector points at a set bit whenever it reports one
    p_lod_hit_r6: assert property (@(posedge clk) disable iff (rst)
        found |-> sum[pos]);
endmodule

// File: rtl/fadd_unit.sv
module fadd_unit #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 18,
    localparam int W = 1 + EXP_W + MAN_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] result,
    output logic         done
);
    typedef struct packed {
        logic             vld;
        logic             sgn;
        logic             eff_sub;
        logic [EXP_W-1:0] exp_big;
        logic [MAN_W-1:0] man_big;
        logic [EXP_W-1:0] exp_sml;
        logic [MAN_W-1:0] man_sml;
    } ord_t;

    typedef struct packed {
        logic             vld;
        logic             sgn;
        logic [EXP_W-1:0] exp;
        logic [MAN_W:0]   sum;
    } alg_t;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] word;
    } out_t;

    typedef struct packed {
        ord_t s1;
        alg_t s2;
        out_t s3;
    } pipe_t;

    pipe_t st_d, st_q;

    logic             o_sgn, o_sub;
    logic [EXP_W-1:0] o_eb, o_es;
    logic [MAN_W-1:0] o_mb, o_ms;
    logic [MAN_W:0]   a_sum;
    logic [W-1:0]     n_word;

    fadd_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_order (
        .a       (a_in),
        .b       (b_in),
        .op      (op),
        .sgn     (o_sgn),
        .eff_sub (o_sub),
        .exp_big (o_eb),
        .man_big (o_mb),
        .exp_sml (o_es),
        .man_sml (o_ms)
    );

    fadd_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
        .eff_sub (st_q.s1.eff_sub),
        .exp_big (st_q.s1.exp_big),
        .man_big (st_q.s1.man_big),
        .exp_sml (st_q.s1.exp_sml),
        .man_sml (st_q.s1.man_sml),
        .sum     (a_sum)
    );

    fadd_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
        .clk    (clk),
        .rst    (rst),
        .sgn    (st_q.s2.sgn),
        .exp_in (st_q.s2.exp),
        .sum    (st_q.s2.sum),
        .word   (n_word)
    );

    always_comb begin
        st_d = st_q;
        // step 1: compare and order
        st_d.s1.vld     = start;
        st_d.s1.sgn     = o_sgn;
        st_d.s1.eff_sub = o_sub;
        st_d.s1.exp_big = o_eb;
        st_d.s1.man_big = o_mb;
        st_d.s1.exp_sml = o_es;
        st_d.s1.man_sml = o_ms;
        // step 2: align and add/subtract
        st_d.s2.vld = st_q.s1.vld;
        st_d.s2.sgn = st_q.s1.sgn;
        st_d.s2.exp = st_q.s1.exp_big;
        st_d.s2.sum = a_sum;
        // step 3: renormalize, hold the word between operations
        st_d.s3.vld = st_q.s2.vld;
        if (st_q.s2.vld)
            st_d.s3.word = n_word;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign result = st_q.s3.word;
    assign done   = st_q.s3.vld;

    // R2: every start yields done three edges later
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> ##2 done);
    // R2: done never appears without a start three edges earlier
    p_done_src_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start, 3));
    // R2: result is held while no operation completes
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));
    // R3: registered ordering never places the smaller magnitude on top
    p_order_r3: assert property (@(posedge clk) disable iff (rst)
        st_q.s1.vld |-> {st_q.s1.exp_big, st_q.s1.man_big} >=
                        {st_q.s1.exp_sml, st_q.s1.man_sml});
    // R1: nonzero results are normalized with a legal exponent
    p_norm_form_r1: assert property (@(posedge clk) disable iff (rst)
        (done && result != '0) |->
            (result[MAN_W-1] && result[W-2:MAN_W] != '0));
    // R7: a zero mantissa only comes as the all-zero word
    p_zero_word_r7: assert property (@(posedge clk) disable iff (rst)
        (done && result[MAN_W-1:0] == '0) |-> result == '0);
endmodule

// File: tb/sim_fadd_unit.sv
module sim_fadd_unit;
    localparam int W = 27;
    localparam int WATCHDOG = 20000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [1:0]   op_i = 2'd0;
    logic [W-1:0] a_i = '0, b_i = '0;
    logic [W-1:0] result;
    logic         done;

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 1'b0;

    int           due_q[$];
    logic [W-1:0] val_q[$];
    string        tag_q[$];

    always #10 clk = ~clk;   // 50 MHz

    fadd_unit u0 (
        .clk(clk), .rst(rst), .start(start), .op(op_i),
        .a_in(a_i), .b_in(b_i), .result(result), .done(done)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [W-1:0] mk(input bit s, input int e, input int m);
        return {s, 8'(e), 18'(m)};
    endfunction

    // behavioural reference: integer arithmetic on fields
    function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic [1:0] op);
        longint mb, ms, m;
        int eb, es, e, d;
        bit sa, sb, s, sub;
        if (op[1]) begin
            m = longint'(a[17:0]);
            if (m == 0) return '0;
            e = 144;
            while (m < (64'd1 << 17)) begin m = m << 1; e--; end
            return {1'b0, 8'(e), 18'(m)};
        end
        sa = a[26];
        sb = b[26] ^ op[0];
        sub = sa ^ sb;
        if (a[25:0] >= b[25:0]) begin
            s = sa; eb = int'(a[25:18]); mb = longint'(a[17:0]);
            es = int'(b[25:18]); ms = longint'(b[17:0]);
        end else begin
            s = sb; eb = int'(b[25:18]); mb = longint'(b[17:0]);
            es = int'(a[25:18]); ms = longint'(a[17:0]);
        end
        d = eb - es;
        ms = (d >= 18) ? 0 : (ms >> d);
        m = sub ? (mb - ms) : (mb + ms);
        e = eb;
        if (m == 0) return '0;
        while (m >= (64'd1 << 18)) begin m = m >> 1; e++; end
        while (m < (64'd1 << 17)) begin m = m << 1; e--; end
        if (e < 1) return '0;
        return {s, 8'(e), 18'(m)};
    endfunction

    task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [1:0] op, input string tag);
        @(negedge clk);
        start = 1'b1; a_i = a; b_i = b; op_i = op;
        due_q.push_back(cyc + 3);
        val_q.push_back(model(a, b, op));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = 1'b0;
        end
    endtask

    function automatic logic [W-1:0] rnd_float();
        if ($urandom_range(9) == 0) return '0;
        return mk($urandom_range(1), $urandom_range(230, 20),
                  32'h20000 | $urandom_range(32'h1FFFF));
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            checks++;
            if (due_q.size() > 0 && due_q[0] == cyc) begin
                if (done !== 1'b1 || result !== val_q[0]) begin
                    errors++;
                    $display("FAIL %s: done=%0b result=%h expected done=1 result=%h",
                             tag_q[0], done, result, val_q[0]);
                end
                void'(due_q.pop_front());
                void'(val_q.pop_front());
                void'(tag_q.pop_front());
            end else if (done !== 1'b0) begin
                errors++;
                $display("FAIL R2: done=%0b expected 0 at cycle %0d", done, cyc);
            end
        end
    end

    initial begin
        while (cyc < WATCHDOG && !finished) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL R2: watchdog expired, %0d results pending", due_q.size());
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] ra, rb;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;   // R2 / R7 reset state
        if (done !== 1'b0 || result !== '0) begin
            errors++;
            $display("FAIL R2: after reset done=%0b result=%h expected 0 and 0", done, result);
        end

        issue(mk(0,127,'h20000), mk(0,127,'h30000), 2'd0, "R1");   // 1.0 + 1.5
        issue(mk(0,127,'h20000), mk(0,127,'h20000), 2'd0, "R5");   // carry to 2.0
        issue(mk(0,127,'h30000), mk(0,127,'h28000), 2'd0, "R5");   // carry, lsb dropped
        issue(mk(0,127,'h20000), mk(0,127,'h20000), 2'd1, "R7");   // exact cancel
        issue(mk(0,127,'h20000), mk(0,128,'h20000), 2'd1, "R3");   // 1 - 2 = -1
        issue(mk(0,128,'h20000), mk(1,128,'h30000), 2'd0, "R3");   // 2 + (-3)
        issue(mk(1,127,'h20000), mk(1,127,'h20000), 2'd1, "R3");   // -1 - (-1)
        issue(mk(1,130,'h24000), mk(1,125,'h3FFFF), 2'd0, "R3");   // neg + neg
        idle(2);
        issue(mk(0,127,'h20000), mk(0,120,'h3FFFF), 2'd0, "R4");   // truncation
        issue(mk(0,140,'h20000), mk(0,123,'h3FFFF), 2'd0, "R4");   // diff 17
        issue(mk(0,140,'h20000), mk(0,122,'h3FFFF), 2'd0, "R4");   // diff 18
        issue(mk(0,140,'h20000), mk(0,100,'h3FFFF), 2'd1, "R4");   // diff 40
        issue(mk(0,130,'h20005), mk(0,130,'h20000), 2'd1, "R6");   // long left shift
        issue(mk(0,130,'h20000), mk(0,129,'h3FFFF), 2'd1, "R6");
        issue(mk(0,3,'h20001),   mk(0,3,'h20000),   2'd1, "R8");   // flush
        issue(mk(0,18,'h20001),  mk(0,18,'h20000),  2'd1, "R8");   // exponent lands on 1
        issue(mk(0,17,'h20001),  mk(0,17,'h20000),  2'd1, "R8");   // exponent 0 -> flush
        issue(mk(0,150,'h2ABCD), '0, 2'd0, "R7");                  // x + 0
        issue('0, mk(0,150,'h2ABCD), 2'd1, "R7");                  // 0 - x
        issue('0, '0, 2'd0, "R7");
        idle(1);
        issue(27'd1,        mk(1,200,'h3FFFF), 2'd2, "R9");
        issue(27'h3FFFF,    '0,                2'd2, "R9");
        issue(27'd0,        mk(0,140,'h20000), 2'd3, "R9");
        issue(27'd1000,     mk(1,77,'h2F0F0),  2'd3, "R9");
        issue(27'h7C00_3E8, '0,                2'd2, "R9");        // upper bits ignored
        idle(3);

        for (int i = 0; i < 300; i++) begin
            ra = rnd_float();
            rb = rnd_float();
            if ($urandom_range(2) == 0 && ra != '0)
                rb = mk($urandom_range(1), int'(ra[25:18]) + $urandom_range(2) - 1,
                        32'h20000 | $urandom_range(32'h1FFFF));
            issue(ra, rb, 2'($urandom_range(3)), "R6");
            if ($urandom_range(4) == 0) idle(1);
        end
        idle(1);
        while (due_q.size() > 0 && !finished) @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule